// File: doc/BRIEF.md
# Low-Power Entry and Wake Controller

This block decides when a processing subsystem drops into a low-power state and when it comes back. Software programs an 8-bit wake-control register. One bit arms entry, and a 3-bit code sets how urgent an interrupt must be before the subsystem is woken.

When a stop request arrives while entry is armed, the controller spends one cycle in a transition state. In that cycle it captures the requested mode code, and it then raises its low-power flag. The flag stays up until a valid pending interrupt request meets the programmed threshold. The controller returns to run on the clock edge that sees such a request.

The block only produces the flag and the mode code. Gating clocks and switching power are left to the logic that consumes these outputs.

Top module: `lpwr_wake_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, the low-power flag is 0 and the mode output is 0.
- R2: A write stores bit 7 as the entry-enable bit and bits 2..0 as the wake threshold code. The register is visible on the read port the cycle after the write. Bits 6..3 always read 0.
- R3: A stop request while the entry-enable bit (bit 7) is 0 leaves the controller in run, and the low-power flag stays 0.
- R4: A stop request in run with entry enabled moves the controller to a transition state at the sampling edge. While in that state the flag and mode output are 0. At the next edge the flag rises, and the mode output shows the mode-select value sampled at that edge. The mode output is 0 whenever the flag is 0.
- R5: With threshold code 000, any valid request of level 1 to 7 wakes the controller. A valid request of level 0 does not wake it.
- R6: With threshold code c from 001 to 101, a valid request wakes the controller only when its level is at least c+1.
- R7: With threshold code 110 or 111, only a valid request of level 7 wakes the controller.
- R8: While the request-valid input is 0, no request level wakes the controller.
- R9: The wake condition, sampled in low-power at one edge, clears the flag at that same edge. The controller is then back in run.
- R10: A stop request during the transition state or in low-power is ignored, and the latched mode output does not change.
- R11: Wake qualification uses the register value held before a write that lands in the same cycle. Clearing the entry-enable bit while in low-power does not force an exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 8 | Write data for the control register |
| cfg_rdata | output | 8 | Current control register value, reserved bits zero |
| stop_req | input | 1 | Software stop request |
| irq_level | input | 3 | Level of the highest pending interrupt request |
| irq_valid | input | 1 | Qualifies irq_level |
| mode_sel | input | 2 | Low-power mode to enter |
| lp_active | output | 1 | Low-power state flag |
| lp_mode | output | 2 | Latched mode code, zero outside low-power |

## Verification
A register write can arrive in the same cycle that a pending interrupt is being judged against the threshold. The bench provokes this while the controller is in low-power. It programs threshold 111, presents a level-3 request, and in that same cycle writes threshold 000. The flag must stay up at that edge and drop at the next one. In a second case, entry-enable is cleared while the controller is asleep, and the flag must hold until a qualifying request arrives.

// File: rtl/lpw_pkg.sv
`timescale 1ns/1ps
package lpw_pkg;
   typedef enum logic [1:0] {
      LPW_RUN   = 2'd0,
      LPW_ENTER = 2'd1,
      LPW_SLEEP = 2'd2
   } lpw_state_e;
endpackage

// File: rtl/lpw_cfg_reg.sv
`timescale 1ns/1ps
module lpw_cfg_reg #(
   parameter int REG_W   = 8,
   parameter int LEVEL_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [REG_W-1:0]   wdata,
   output logic [REG_W-1:0]   rdata,
   output logic               entry_en,
   output logic [LEVEL_W-1:0] wake_thr
);
   localparam int EN_BIT = REG_W - 1;
   localparam logic [REG_W-1:0] KEEP_MASK =
      {1'b1, {(REG_W-1-LEVEL_W){1'b0}}, {LEVEL_W{1'b1}}};

   logic               en_q;
   logic [LEVEL_W-1:0] thr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         thr_q <= '0;
      end else if (we) begin
         en_q  <= wdata[EN_BIT];
         thr_q <= wdata[LEVEL_W-1:0];
      end
   end

   always_comb begin
      rdata                 = '0;
      rdata[EN_BIT]         = en_q;
      rdata[LEVEL_W-1:0]    = thr_q;
   end

   assign entry_en = en_q;
   assign wake_thr = thr_q;

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[REG_W-2:LEVEL_W] == '0);                               // R2
   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> rdata == ($past(wdata) & KEEP_MASK));                   // R2
endmodule

// File: rtl/lpw_wake_cmp.sv
`timescale 1ns/1ps
module lpw_wake_cmp #(
   parameter int LEVEL_W  = 3,
   parameter bit USE_MASK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LEVEL_W-1:0] thr,
   input  logic [LEVEL_W-1:0] level,
   input  logic               valid,
   output logic               wake
);
   localparam int NUM_LVL = 1 << LEVEL_W;
   localparam logic [LEVEL_W-1:0] MAX_LVL = '1;
   localparam logic [LEVEL_W-1:0] TOP_THR = {{(LEVEL_W-1){1'b1}}, 1'b0};
   localparam logic [LEVEL_W-1:0] ONE_LVL = {{(LEVEL_W-1){1'b0}}, 1'b1};

   logic [LEVEL_W-1:0] min_lvl;

   always_comb begin
      if (thr == '0)           min_lvl = ONE_LVL;
      else if (thr >= TOP_THR) min_lvl = MAX_LVL;
      else                     min_lvl = thr + ONE_LVL;
   end

   generate
      if (USE_MASK) begin : g_mask
         logic [NUM_LVL-1:0] hit;
         for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
            assign hit[l] = (l != 0) && (LEVEL_W'(l) >= min_lvl);
         end
         assign wake = valid && hit[level];
      end else begin : g_arith
         assign wake = valid && (level != '0) && (level >= min_lvl);
      end
   endgenerate

   AST_INVALID_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> !wake);                                             // R8
   AST_ZERO_CODE_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (thr == '0 && valid && level != '0) |-> wake);                 // R5
   AST_TOP_CODES: assert property (@(posedge clk) disable iff (!rst_n)
      (thr >= TOP_THR && wake) |-> level == MAX_LVL);                // R7
   AST_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0) |-> !wake);                                      // R5
endmodule

// File: rtl/lpw_fsm.sv
`timescale 1ns/1ps
module lpw_fsm
   import lpw_pkg::*;
#(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_req,
   input  logic              entry_en,
   input  logic              wake,
   input  logic [MODE_W-1:0] mode_sel,
   output logic              lp_active,
   output logic [MODE_W-1:0] lp_mode
);
   lpw_state_e        state_q, state_d;
   logic [MODE_W-1:0] mode_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LPW_RUN:   if (stop_req && entry_en) state_d = LPW_ENTER;
         LPW_ENTER: state_d = LPW_SLEEP;
         LPW_SLEEP: if (wake) state_d = LPW_RUN;
         default:   state_d = LPW_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LPW_RUN;
         mode_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == LPW_ENTER) mode_q <= mode_sel;
      end
   end

   assign lp_active = (state_q == LPW_SLEEP);
   assign lp_mode   = lp_active ? mode_q : '0;

   AST_NO_ENTRY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPW_RUN && !entry_en) |=> state_q == LPW_RUN);    // R3
   AST_ENTER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPW_ENTER) |=> (lp_active && lp_mode == $past(mode_sel))); // R4
   AST_MODE_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lp_active |-> lp_mode == '0);                                 // R4
   AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPW_SLEEP && wake) |=> state_q == LPW_RUN);       // R9
   AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPW_SLEEP && !wake) |=> (lp_active && $stable(lp_mode))); // R10
endmodule

// File: rtl/lpwr_wake_ctrl.sv
`timescale 1ns/1ps
module lpwr_wake_ctrl #(
   parameter int MODE_W   = 2,
   parameter int LEVEL_W  = 3,
   parameter int REG_W    = 8,
   parameter bit USE_MASK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [REG_W-1:0]   cfg_wdata,
   output logic [REG_W-1:0]   cfg_rdata,
   input  logic               stop_req,
   input  logic [LEVEL_W-1:0] irq_level,
   input  logic               irq_valid,
   input  logic [MODE_W-1:0]  mode_sel,
   output logic               lp_active,
   output logic [MODE_W-1:0]  lp_mode
);
   generate
      if (LEVEL_W < 2 || LEVEL_W > 6) begin : g_bad_level
         $error("lpwr_wake_ctrl: LEVEL_W must lie in 2..6");
      end
      if (REG_W < LEVEL_W + 2) begin : g_bad_reg
         $error("lpwr_wake_ctrl: REG_W too small for enable, reserved and threshold");
      end
      if (MODE_W < 1) begin : g_bad_mode
         $error("lpwr_wake_ctrl: MODE_W must be at least 1");
      end
   endgenerate

   logic               entry_en;
   logic [LEVEL_W-1:0] wake_thr;
   logic               wake;

   lpw_cfg_reg #(.REG_W(REG_W), .LEVEL_W(LEVEL_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .wdata    (cfg_wdata),
      .rdata    (cfg_rdata),
      .entry_en (entry_en),
      .wake_thr (wake_thr)
   );

   lpw_wake_cmp #(.LEVEL_W(LEVEL_W), .USE_MASK(USE_MASK)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .thr   (wake_thr),
      .level (irq_level),
      .valid (irq_valid),
      .wake  (wake)
   );

   lpw_fsm #(.MODE_W(MODE_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop_req  (stop_req),
      .entry_en  (entry_en),
      .wake      (wake),
      .mode_sel  (mode_sel),
      .lp_active (lp_active),
      .lp_mode   (lp_mode)
   );

   AST_WRITE_NO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_active && !irq_valid) |=> lp_active);                     // R11
endmodule

// File: tb/test_lpwr_wake_ctrl.sv
`timescale 1ns/1ps
module test_lpwr_wake_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       stop_req = 1'b0;
   logic [2:0] irq_level = '0;
   logic       irq_valid = 1'b0;
   logic [1:0] mode_sel = '0;
   logic       lp_active;
   logic [1:0] lp_mode;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lpwr_wake_ctrl i_lpwr_wake_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .stop_req(stop_req), .irq_level(irq_level),
      .irq_valid(irq_valid), .mode_sel(mode_sel), .lp_active(lp_active),
      .lp_mode(lp_mode)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      cfg_we = 1'b1; cfg_wdata = d;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic enter(input logic [1:0] m, input string req);
      stop_req = 1'b1;
      step();
      chk({req, " R4 transition flag"}, int'(lp_active), 0);
      chk({req, " R4 transition mode"}, int'(lp_mode), 0);
      stop_req = 1'b0; mode_sel = m;
      step();
      chk({req, " R4 entered flag"}, int'(lp_active), 1);
      chk({req, " R4 entered mode"}, int'(lp_mode), int'(m));
   endtask

   function automatic int min_level(input int thr);
      if (thr == 0) return 1;
      if (thr >= 6) return 7;
      return thr + 1;
   endfunction

   initial begin
      #200000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 rdata", int'(cfg_rdata), 0);
      chk("R1 flag", int'(lp_active), 0);
      chk("R1 mode", int'(lp_mode), 0);

      // R2 register fields
      wr(8'hFF);
      chk("R2 all ones", int'(cfg_rdata), 'h87);
      wr(8'h78);
      chk("R2 reserved only", int'(cfg_rdata), 0);
      wr(8'h85);
      chk("R2 enable+thr", int'(cfg_rdata), 'h85);

      // R3 entry disabled
      wr(8'h07);
      stop_req = 1'b1; mode_sel = 2'd3;
      step(); step();
      chk("R3 no entry", int'(lp_active), 0);
      step();
      chk("R3 no entry later", int'(lp_active), 0);
      stop_req = 1'b0;

      // R5 R6 R7 R8 R9 sweep
      for (int thr = 0; thr < 8; thr++) begin
         for (int v = 0; v < 2; v++) begin
            for (int lvl = 0; lvl < 8; lvl++) begin
               string tag;
               bit exp_wake;
               tag = (v == 0) ? "R8" : (thr == 0) ? "R5" : (thr >= 6) ? "R7" : "R6";
               wr(8'h80 | 8'(thr));
               enter(2'(thr + lvl), tag);
               exp_wake = (v == 1) && (lvl != 0) && (lvl >= min_level(thr));
               irq_level = 3'(lvl); irq_valid = v[0];
               step();
               chk($sformatf("%s thr=%0d lvl=%0d v=%0d", tag, thr, lvl, v),
                   int'(lp_active), exp_wake ? 0 : 1);
               irq_valid = 1'b0;
               if (!exp_wake) begin
                  irq_level = 3'd7; irq_valid = 1'b1;
                  step();
                  chk("R9 level7 exit", int'(lp_active), 0);
                  chk("R9 mode cleared", int'(lp_mode), 0);
                  irq_valid = 1'b0;
               end
            end
         end
      end

      // R10 stop ignored during sleep
      wr(8'h87);
      enter(2'd1, "R10");
      stop_req = 1'b1; mode_sel = 2'd3;
      step();
      chk("R10 still asleep", int'(lp_active), 1);
      chk("R10 mode kept", int'(lp_mode), 1);
      step();
      chk("R10 mode kept again", int'(lp_mode), 1);
      stop_req = 1'b0;
      irq_level = 3'd7; irq_valid = 1'b1;
      step();
      irq_valid = 1'b0;
      chk("R10 exit", int'(lp_active), 0);

      // R11 write in the same cycle as wake judgement
      enter(2'd2, "R11");
      irq_level = 3'd3; irq_valid = 1'b1;
      cfg_we = 1'b1; cfg_wdata = 8'h80;
      step();
      cfg_we = 1'b0;
      chk("R11 old threshold governs", int'(lp_active), 1);
      chk("R11 new value visible", int'(cfg_rdata), 'h80);
      step();
      chk("R11 new threshold wakes", int'(lp_active), 0);
      irq_valid = 1'b0;

      // R11 clearing enable while asleep
      enter(2'd1, "R11b");
      wr(8'h00);
      chk("R11 no forced exit", int'(lp_active), 1);
      step();
      chk("R11 still asleep", int'(lp_active), 1);
      irq_level = 3'd1; irq_valid = 1'b1;
      step();
      irq_valid = 1'b0;
      chk("R11 wake thr0", int'(lp_active), 0);
      stop_req = 1'b1;
      step(); step();
      chk("R3 no reentry", int'(lp_active), 0);
      stop_req = 1'b0;

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule